// File: doc/BRIEF.md
# Oversampled Output Sample Sequencer

This block drives two DAC channels at a rate several times higher than the bus cycle. During each bus cycle, the host loads a packet of 16-bit samples for each channel into a staging buffer and then marks the packet complete. A cycle-start sync pulse makes the completed packet live. The block puts out sample 0 at once. After that, a sub-period timer releases each following sample at evenly spaced instants until the last sample of the packet has been sent.

The two channels always share one oversampling factor and one sub-period. Both values are taken from the configuration inputs at sync. The sub-period timer compares a free-running tick count with a deadline in a way that stays correct when the count wraps. Two sticky flags report timing faults:
- A sync that cuts a running packet short sets the overrun flag.
- A sync that finds no newly completed packet sets the underrun flag. The block then replays the live packet.

Top module: `ovs_seq`

## Requirements
- R1: While reset is asserted and after it is released, both update strobes are 0 and both fault flags are 0 until the first sync.
- R2: The cycle after a sync edge, both channels strobe and present index 0 of the packet that became live at that sync.
- R3: Index k (0 ≤ k < F) strobes exactly k·P clock cycles after index 0 and carries packet word k. F is the factor and P is the sub-period, both sampled at the sync edge.
- R4: After index F−1, no strobe occurs until the next sync. With F = 1, only index 0 is output.
- R5: The two channels strobe on the same clock edge, and each presents its own packet word.
- R6: Word writes (channel, index, data) go only to the staging buffer. They never change the values output during the cycle already running. A packet becomes live only at the first sync after a commit.
- R7: A sync that arrives while samples of the current packet are still pending abandons them and restarts at index 0. It also sets the overrun flag, which stays at 1 until reset.
- R8: A sync with no commit since the previous swap replays the live packet and sets the underrun flag, which stays at 1 until reset.
- R9: Strobe spacing is exact even when the internal tick count wraps. This requires P < 2^(TW−1).
- R10: Changes to the factor and sub-period inputs between syncs do not affect the cycle in progress. A factor of 0 is treated as 1, and a factor above MAXF is treated as MAXF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write one word into the staging buffer |
| wr_ch | input | CW | Channel of the word being written |
| wr_idx | input | AW | Sample index of the word being written |
| wr_data | input | DW | Sample value |
| commit | input | 1 | Marks the staged packet complete for the next sync |
| sync | input | 1 | Bus-cycle start pulse |
| cfg_factor | input | FW | Samples per bus cycle, 1..MAXF |
| cfg_period | input | PW | Sub-period in clock ticks, at least 1 |
| dac_data | output | NCH*DW | Per-channel DAC word; channel c occupies bits [c*DW +: DW] |
| dac_upd | output | NCH | One-clock update strobe per channel |
| overrun | output | 1 | Sticky: a sync cut a packet short |
| underrun | output | 1 | Sticky: a sync found no new packet |

## Verification
The bench builds the block with a 10-bit tick count and an 8-bit sub-period, with MAXF = 32 and two channels. The narrow tick count wraps every 1024 clocks, so the long random sequence crosses many wrap points in the middle of a cycle and tests the wrap-safe deadline compare. Sub-periods reach 12 ticks and factors reach the full 32, so the bench covers back-to-back strobes at P = 1, the single-sample case, and full-depth packets. Random early syncs, replays, staging writes during a run, and configuration changes during a run exercise overrun, underrun, double buffering, and configuration latching against a bench model.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  // action requested from the deadline timer
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_RESTART = 2'd1,
    ACT_STEP    = 2'd2
  } ovs_act_e;
endpackage

// File: rtl/ovs_timer.sv
module ovs_timer
  import ovs_pkg::*;
#(
  parameter int TW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ovs_act_e      act,
  input  logic [PW-1:0] period,
  output logic          due_hit
);
  logic [TW-1:0] now_q, due_q, due_d, diff;

  always_comb begin
    due_d = due_q;
    case (act)
      ACT_RESTART: due_d = now_q + TW'(period);
      ACT_STEP:    due_d = due_q + TW'(period);
      default:     due_d = due_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      due_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (act != ACT_HOLD) due_q <= due_d;
    end
  end

  // wrap-safe: deadline reached when (now - due) is non-negative
  assign diff    = now_q - due_q;
  assign due_hit = ~diff[TW-1];
endmodule

// File: rtl/ovs_step.sv
module ovs_step
  import ovs_pkg::*;
#(
  parameter int MAXF = 32,
  parameter int PW   = 16,
  localparam int FW  = $clog2(MAXF + 1),
  localparam int AW  = (MAXF > 1) ? $clog2(MAXF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  input  logic          due_hit,
  input  logic          pend,
  input  logic [FW-1:0] cfg_factor,
  input  logic [PW-1:0] cfg_period,
  output ovs_act_e      act,
  output logic [PW-1:0] tm_period,
  output logic [AW-1:0] rd_idx,
  output logic          fire,
  output logic          run,
  output logic          ovr,
  output logic          und
);
  logic [FW-1:0] idx_q, idx_d, fac_q, fac_d, fac_c;
  logic [PW-1:0] per_q, per_d;
  logic          run_q, run_d, ovr_q, ovr_d, und_q, und_d;

  always_comb begin
    if (cfg_factor == '0)                  fac_c = FW'(1);
    else if (cfg_factor > FW'(MAXF))       fac_c = FW'(MAXF);
    else                                   fac_c = cfg_factor;
  end

  always_comb begin
    act   = ACT_HOLD;
    fire  = 1'b0;
    idx_d = idx_q;
    fac_d = fac_q;
    per_d = per_q;
    run_d = run_q;
    ovr_d = ovr_q;
    und_d = und_q;
    if (sync) begin
      act   = ACT_RESTART;
      fire  = 1'b1;
      idx_d = FW'(1);
      fac_d = fac_c;
      per_d = cfg_period;
      run_d = (fac_c > FW'(1));
      ovr_d = ovr_q | run_q;
      und_d = und_q | ~pend;
    end else if (run_q && due_hit) begin
      act   = ACT_STEP;
      fire  = 1'b1;
      idx_d = idx_q + 1'b1;
      run_d = ((idx_q + 1'b1) != fac_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      fac_q <= FW'(1);
      per_q <= '0;
      run_q <= 1'b0;
      ovr_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      if (act != ACT_HOLD) begin
        idx_q <= idx_d;
        run_q <= run_d;
      end
      if (sync) begin
        fac_q <= fac_d;
        per_q <= per_d;
      end
      ovr_q <= ovr_d;
      und_q <= und_d;
    end
  end

  assign tm_period = sync ? cfg_period : per_q;
  assign rd_idx    = sync ? '0 : idx_q[AW-1:0];
  assign run       = run_q;
  assign ovr       = ovr_q;
  assign und       = und_q;
endmodule

// File: rtl/ovs_buf.sv
module ovs_buf #(
  parameter int NCH  = 2,
  parameter int DW   = 16,
  parameter int MAXF = 32,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = (MAXF > 1) ? $clog2(MAXF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_ch,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              commit,
  input  logic              swap_req,
  input  logic [AW-1:0]     rd_idx,
  output logic              pend,
  output logic [NCH*DW-1:0] rd_data
);
  logic [DW-1:0] shd_q [NCH][MAXF];
  logic [DW-1:0] liv_q [NCH][MAXF];
  logic          pend_q, pend_d, swap;

  assign swap   = swap_req & pend_q;
  assign pend_d = commit | (pend_q & ~swap_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // storage arrays carry no reset
  always_ff @(posedge clk) begin
    if (wr_en) shd_q[wr_ch][wr_idx] <= wr_data;
    if (swap)  liv_q <= shd_q;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rd
    assign rd_data[c*DW +: DW] = swap ? shd_q[c][rd_idx] : liv_q[c][rd_idx];
  end

  assign pend = pend_q;
endmodule

// File: rtl/ovs_seq.sv
module ovs_seq
  import ovs_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int DW   = 16,
  parameter int MAXF = 32,
  parameter int PW   = 16,
  parameter int TW   = 32,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = (MAXF > 1) ? $clog2(MAXF) : 1,
  localparam int FW  = $clog2(MAXF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_ch,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              commit,
  input  logic              sync,
  input  logic [FW-1:0]     cfg_factor,
  input  logic [PW-1:0]     cfg_period,
  output logic [NCH*DW-1:0] dac_data,
  output logic [NCH-1:0]    dac_upd,
  output logic              overrun,
  output logic              underrun
);
  logic [1:0]        rs_q;
  logic              rst_q;
  ovs_act_e          act;
  logic [PW-1:0]     tm_period;
  logic [AW-1:0]     rd_idx;
  logic              due_hit, fire, run_w, pend_w;
  logic [NCH*DW-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  ovs_timer #(.TW(TW), .PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_q), .act(act), .period(tm_period), .due_hit(due_hit)
  );

  ovs_step #(.MAXF(MAXF), .PW(PW)) u_step (
    .clk(clk), .rst_n(rst_q), .sync(sync), .due_hit(due_hit), .pend(pend_w),
    .cfg_factor(cfg_factor), .cfg_period(cfg_period), .act(act),
    .tm_period(tm_period), .rd_idx(rd_idx), .fire(fire), .run(run_w),
    .ovr(overrun), .und(underrun)
  );

  ovs_buf #(.NCH(NCH), .DW(DW), .MAXF(MAXF)) u_buf (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_ch(wr_ch), .wr_idx(wr_idx),
    .wr_data(wr_data), .commit(commit), .swap_req(sync), .rd_idx(rd_idx),
    .pend(pend_w), .rd_data(rd_data)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_dac
    logic [DW-1:0] dat_q;
    logic          upd_q;
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        dat_q <= '0;
        upd_q <= 1'b0;
      end else begin
        upd_q <= fire;
        if (fire) dat_q <= rd_data[c*DW +: DW];
      end
    end
    assign dac_data[c*DW +: DW] = dat_q;
    assign dac_upd[c]           = upd_q;
  end
endmodule

// File: rtl/ovs_seq_chk.sv
module ovs_seq_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sync,
  input logic [NCH-1:0] upd,
  input logic           run,
  input logic           pend,
  input logic           ovr,
  input logic           und
);
  p_first_on_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (&upd));
  p_start_needs_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(sync));
  p_quiet_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !run) |=> (upd == '0));
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && run) |=> ovr);
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
  p_und_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !pend) |=> und);
  p_und_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    und |=> und);
endmodule

bind ovs_seq ovs_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_q), .sync(sync), .upd(dac_upd), .run(run_w),
  .pend(pend_w), .ovr(overrun), .und(underrun)
);

// File: tb/ovs_seq_tb.sv
module ovs_seq_tb;
  localparam int NCH = 2, DW = 16, MAXF = 32, PW = 8, TW = 10;
  localparam int CW = 1, AW = 5, FW = 6;

  logic clk = 1'b0, rst_n;
  logic wr_en, commit, sync;
  logic [CW-1:0] wr_ch;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [FW-1:0] cfg_factor;
  logic [PW-1:0] cfg_period;
  logic [NCH*DW-1:0] dac_data;
  logic [NCH-1:0] dac_upd;
  logic overrun, underrun;

  int vecs = 0, errs = 0;
  bit ovr_m = 0, und_m = 0, prev_valid = 0;
  int prev_len = 0, prev_last = 0, prev_f = 1;
  logic [DW-1:0] mdl [NCH][MAXF];

  always #4 clk = ~clk;

  ovs_seq #(.NCH(NCH), .DW(DW), .MAXF(MAXF), .PW(PW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_idx(wr_idx),
    .wr_data(wr_data), .commit(commit), .sync(sync), .cfg_factor(cfg_factor),
    .cfg_period(cfg_period), .dac_data(dac_data), .dac_upd(dac_upd),
    .overrun(overrun), .underrun(underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: optional new packet, sync, then len sampled cycles
  task automatic cycle(input int f, input int p, input bit wr_new, input int len);
    logic [DW-1:0] nw [NCH][MAXF];
    int k = 0;
    if (wr_new) begin
      for (int c = 0; c < NCH; c++)
        for (int i = 0; i < f; i++) begin
          @(negedge clk);
          wr_en = 1; wr_ch = CW'(c); wr_idx = AW'(i); wr_data = DW'($urandom);
          nw[c][i] = wr_data; k++;
        end
      @(negedge clk); wr_en = 0; commit = 1; k++;
    end
    @(negedge clk);
    wr_en = 0; commit = 0; sync = 1; k++;
    cfg_factor = FW'(f); cfg_period = PW'(p);
    if (prev_valid && (prev_len + k <= prev_last)) ovr_m = 1;
    if (!wr_new) und_m = 1;
    else for (int c = 0; c < NCH; c++) for (int i = 0; i < f; i++) mdl[c][i] = nw[c][i];
    for (int t = 0; t < len; t++) begin
      bit eu;
      @(negedge clk);
      if (t == 0) begin
        sync = 0;
        chk("R7 overrun", 32'(overrun), 32'(ovr_m));
        chk("R8 underrun", 32'(underrun), 32'(und_m));
      end
      eu = (t % p == 0) && (t / p < f);
      chk(eu ? (t == 0 ? "R2 upd0" : "R3/R9 upd0") : "R4 upd0", 32'(dac_upd[0]), 32'(eu));
      chk("R5 upd1", 32'(dac_upd[1]), 32'(eu));
      if (eu) begin
        // R6: staging writes below must never reach these values
        chk(t == 0 ? "R2 data0" : "R3 data0", 32'(dac_data[DW-1:0]), 32'(mdl[0][t/p]));
        chk("R5 data1", 32'(dac_data[2*DW-1:DW]), 32'(mdl[1][t/p]));
      end
      // R6/R10: disturb staging buffer and configuration mid-cycle
      wr_en = 1'($urandom); wr_ch = CW'($urandom); wr_idx = AW'($urandom);
      wr_data = DW'($urandom);
      cfg_factor = FW'($urandom); cfg_period = PW'($urandom);
    end
    prev_valid = 1; prev_len = len; prev_last = (f - 1) * p; prev_f = f;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    rst_n = 0; wr_en = 0; commit = 0; sync = 0;
    wr_ch = '0; wr_idx = '0; wr_data = '0; cfg_factor = 6'd1; cfg_period = 8'd1;
    repeat (3) @(negedge clk);
    chk("R1 upd", 32'(dac_upd), 32'd0);
    chk("R1 overrun", 32'(overrun), 32'd0);
    chk("R1 underrun", 32'(underrun), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 upd after release", 32'(dac_upd), 32'd0);

    cycle(1, 3, 1, 6);             // R4: single sample
    cycle(32, 1, 1, 34);           // R3: full depth, back-to-back
    cycle(32, 2, 0, 66);           // R8: replay
    cycle(32, 3, 1, 10);           // cut short
    cycle(5, 2, 1, 12);            // R7: overrun from the previous cycle
    for (int n = 0; n < 60; n++) begin
      bit wn = ($urandom % 4) != 0;
      int f = wn ? 1 + ($urandom % MAXF) : prev_f;
      int p = 1 + ($urandom % 12);
      int len = (($urandom % 4) == 0) ? 1 + ($urandom % (f * p)) : f * p + 2;
      cycle(f, p, wn, len);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule